// File: doc/BRIEF.md
# Stream End-of-Burst Marker Insert/Strip Unit

This unit sits on a valid/ready data path and handles the end-of-burst flag in one of two ways fixed at build time. In insert mode it accepts a plain stream and produces an AXI4-Stream output whose TLAST is high on the beat that closes each group of N accepted transfers. In strip mode it accepts an AXI4-Stream input, forwards each data word unchanged, and discards the incoming TLAST. The output TLAST is then held low.

The group length N comes either from a build-time parameter or from a 32-bit register that software writes through a small AXI4-Lite slave. In dynamic mode the value is captured when the first beat of a group is accepted. A write made while a group is in progress therefore takes effect from the next group. The data path has one register stage. The input ready follows the output ready, so backpressure passes straight through and no beat is lost or repeated. Setting the direction parameter to any value other than insert (0) or strip (1) stops elaboration with a fatal error.

Top module: `burst_mark_unit`

## Requirements
- R1: In insert mode with the dynamic count, m_axis_tlast is 1 on the beat that completes each group of N accepted beats and 0 on every other beat. N is the register value captured at the group's first beat.
- R2: A write to byte offset 0x10 (address bits [1:0] ignored) sets the 32-bit group-length register. A read of offset 0x10 returns the stored value.
- R3: In insert mode with the static count, the group length is the build parameter STATIC_LEN, and writes to the register have no effect on where TLAST falls.
- R4: After the beat that carries TLAST, the next accepted beat starts a new group at position 1. Groups follow one another with no gap or overlap.
- R5: A register write accepted while a group is in progress does not move that group's final beat. The new value applies from the following group. A write accepted on the same clock edge as a group's first beat does not apply to that group.
- R6: A group length of 0 behaves as 1: every beat carries TLAST.
- R7: In strip mode every input data word appears on m_axis_tdata unchanged and in order, and m_axis_tlast is 0 whatever s_axis_tlast carries.
- R8: A beat moves only when valid and ready are both high. While m_axis_tvalid is high and m_axis_tready is low, the output stays valid with data and TLAST unchanged. No beat is lost or duplicated.
- R9: Synchronous active-low reset clears m_axis_tvalid, restarts the beat position at 1, and sets the group-length register to 1.
- R10: Every write and read gets an OKAY response (code 0). A read of any offset other than 0x10 returns 0, and a write to such an offset leaves the register unchanged. Write and read responses stay valid until accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| s_axis_tvalid | input | 1 | Input beat valid |
| s_axis_tready | output | 1 | Input beat ready |
| s_axis_tdata | input | DATA_W | Input data |
| s_axis_tlast | input | 1 | Input end-of-burst flag (discarded) |
| m_axis_tvalid | output | 1 | Output beat valid |
| m_axis_tready | input | 1 | Output beat ready |
| m_axis_tdata | output | DATA_W | Output data |
| m_axis_tlast | output | 1 | Output end-of-burst flag |
| ctl_awaddr | input | ADDR_W | Write address |
| ctl_awvalid | input | 1 | Write address valid |
| ctl_awready | output | 1 | Write address ready |
| ctl_wdata | input | 32 | Write data |
| ctl_wvalid | input | 1 | Write data valid |
| ctl_wready | output | 1 | Write data ready |
| ctl_bresp | output | 2 | Write response |
| ctl_bvalid | output | 1 | Write response valid |
| ctl_bready | input | 1 | Write response ready |
| ctl_araddr | input | ADDR_W | Read address |
| ctl_arvalid | input | 1 | Read address valid |
| ctl_arready | output | 1 | Read address ready |
| ctl_rdata | output | 32 | Read data |
| ctl_rresp | output | 2 | Read response |
| ctl_rvalid | output | 1 | Read data valid |
| ctl_rready | input | 1 | Read data ready |

## Verification
Two events can fall on the same clock edge: a register write being accepted, and the first beat of a group capturing its length. The bench issues writes while random valid and ready patterns keep groups opening at unpredictable edges, including two writes a few cycles apart so that one lands inside a group. The reference model applies each write only after it has evaluated the beats of that edge, so any early or late capture shows up as a misplaced TLAST. The other collision is a group-closing beat meeting a stalled output. Full-stall windows test this, and the bench checks that the held word and flag stay unchanged until they are taken.

// File: rtl/bmu_pkg.sv
package bmu_pkg;
    localparam int unsigned DIR_INSERT   = 0;
    localparam int unsigned DIR_STRIP    = 1;
    localparam int unsigned REG_W        = 32;
    localparam int unsigned LEN_BYTE_OFS = 16;
    localparam logic [1:0]  RESP_OKAY    = 2'b00;
endpackage

// File: rtl/bmu_lite_reg.sv
module bmu_lite_reg
    import bmu_pkg::*;
#(
    parameter int unsigned ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] awaddr_i,
    input  logic              awvalid_i,
    output logic              awready_o,
    input  logic [REG_W-1:0]  wdata_i,
    input  logic              wvalid_i,
    output logic              wready_o,
    output logic [1:0]        bresp_o,
    output logic              bvalid_o,
    input  logic              bready_i,
    input  logic [ADDR_W-1:0] araddr_i,
    input  logic              arvalid_i,
    output logic              arready_o,
    output logic [REG_W-1:0]  rdata_o,
    output logic [1:0]        rresp_o,
    output logic              rvalid_o,
    input  logic              rready_i,
    output logic [REG_W-1:0]  len_o
);
    localparam logic [ADDR_W-1:0] OFS = ADDR_W'(LEN_BYTE_OFS);

    typedef struct packed {
        logic             bvalid;
        logic             rvalid;
        logic [REG_W-1:0] rdata;
        logic [REG_W-1:0] len;
    } lite_st_t;

    lite_st_t st_d, st_q;
    logic     wr_take, rd_take;

    logic unused_lsb;
    assign unused_lsb = ^{awaddr_i[1:0], araddr_i[1:0]};

    always_comb begin
        st_d    = st_q;
        wr_take = awvalid_i && wvalid_i && !st_q.bvalid;
        rd_take = arvalid_i && !st_q.rvalid;
        if (st_q.bvalid && bready_i) st_d.bvalid = 1'b0;
        if (wr_take) begin
            st_d.bvalid = 1'b1;
            if (awaddr_i[ADDR_W-1:2] == OFS[ADDR_W-1:2]) st_d.len = wdata_i;
        end
        if (st_q.rvalid && rready_i) st_d.rvalid = 1'b0;
        if (rd_take) begin
            st_d.rvalid = 1'b1;
            st_d.rdata  = (araddr_i[ADDR_W-1:2] == OFS[ADDR_W-1:2]) ? st_q.len : '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.bvalid <= 1'b0;
            st_q.rvalid <= 1'b0;
            st_q.rdata  <= '0;
            st_q.len    <= REG_W'(1);
        end else begin
            st_q <= st_d;
        end
    end

    assign awready_o = wr_take;
    assign wready_o  = wr_take;
    assign bvalid_o  = st_q.bvalid;
    assign bresp_o   = RESP_OKAY;
    assign arready_o = !st_q.rvalid;
    assign rvalid_o  = st_q.rvalid;
    assign rdata_o   = st_q.rdata;
    assign rresp_o   = RESP_OKAY;
    assign len_o     = st_q.len;

    assert_bresp_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        bvalid_o && !bready_i |=> bvalid_o);
    assert_rdata_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rvalid_o && !rready_i |=> rvalid_o && $stable(rdata_o));
endmodule

// File: rtl/bmu_beat_count.sv
module bmu_beat_count #(
    parameter int unsigned CW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          step_i,
    input  logic [CW-1:0] len_i,
    output logic          last_o
);
    typedef struct packed {
        logic [CW-1:0] cnt;
        logic [CW-1:0] len;
    } cnt_st_t;

    cnt_st_t       st_d, st_q;
    logic [CW-1:0] live_len, eff_len;
    logic          first_beat;

    always_comb begin
        live_len   = (len_i == '0) ? CW'(1) : len_i;
        first_beat = (st_q.cnt == CW'(1));
        eff_len    = first_beat ? live_len : st_q.len;
        last_o     = (st_q.cnt >= eff_len);
        st_d       = st_q;
        if (step_i) begin
            if (first_beat) st_d.len = live_len;
            st_d.cnt = last_o ? CW'(1) : st_q.cnt + CW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.cnt <= CW'(1);
            st_q.len <= CW'(1);
        end else begin
            st_q <= st_d;
        end
    end

    assert_restart_R4: assert property (@(posedge clk) disable iff (!rst_n)
        step_i && last_o |=> st_q.cnt == CW'(1));
    assert_len_frozen_R5: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt != CW'(1) |=> $stable(st_q.len));
    assert_cnt_nonzero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt != '0);
endmodule

// File: rtl/bmu_out_stage.sv
module bmu_out_stage #(
    parameter int unsigned DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          s_valid_i,
    output logic          s_ready_o,
    input  logic [DW-1:0] s_data_i,
    input  logic          s_last_i,
    output logic          m_valid_o,
    input  logic          m_ready_i,
    output logic [DW-1:0] m_data_o,
    output logic          m_last_o,
    output logic          xfer_o
);
    typedef struct packed {
        logic          valid;
        logic          last;
        logic [DW-1:0] data;
    } stage_st_t;

    stage_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        s_ready_o = !st_q.valid || m_ready_i;
        xfer_o    = s_valid_i && s_ready_o;
        if (xfer_o) begin
            st_d.valid = 1'b1;
            st_d.data  = s_data_i;
            st_d.last  = s_last_i;
        end else if (m_ready_i) begin
            st_d.valid = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.valid <= 1'b0;
            st_q.last  <= 1'b0;
            st_q.data  <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign m_valid_o = st_q.valid;
    assign m_data_o  = st_q.data;
    assign m_last_o  = st_q.last;

    assert_stall_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        m_valid_o && !m_ready_i |=> m_valid_o && $stable(m_data_o) && $stable(m_last_o));
    assert_take_on_free_R8: assert property (@(posedge clk) disable iff (!rst_n)
        s_valid_i && !m_valid_o |=> m_valid_o && m_data_o == $past(s_data_i));
endmodule

// File: rtl/burst_mark_unit.sv
module burst_mark_unit
    import bmu_pkg::*;
#(
    parameter int unsigned DATA_W     = 32,
    parameter int unsigned DIRECTION  = DIR_INSERT,
    parameter int unsigned DYNAMIC    = 1,
    parameter int unsigned STATIC_LEN = 8,
    parameter int unsigned ADDR_W     = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              s_axis_tvalid,
    output logic              s_axis_tready,
    input  logic [DATA_W-1:0] s_axis_tdata,
    input  logic              s_axis_tlast,
    output logic              m_axis_tvalid,
    input  logic              m_axis_tready,
    output logic [DATA_W-1:0] m_axis_tdata,
    output logic              m_axis_tlast,
    input  logic [ADDR_W-1:0] ctl_awaddr,
    input  logic              ctl_awvalid,
    output logic              ctl_awready,
    input  logic [REG_W-1:0]  ctl_wdata,
    input  logic              ctl_wvalid,
    output logic              ctl_wready,
    output logic [1:0]        ctl_bresp,
    output logic              ctl_bvalid,
    input  logic              ctl_bready,
    input  logic [ADDR_W-1:0] ctl_araddr,
    input  logic              ctl_arvalid,
    output logic              ctl_arready,
    output logic [REG_W-1:0]  ctl_rdata,
    output logic [1:0]        ctl_rresp,
    output logic              ctl_rvalid,
    input  logic              ctl_rready
);
    logic [REG_W-1:0] cfg_len;
    logic             beat_last;
    logic             in_xfer;
    logic             unused_bits;

    assign unused_bits = ^{cfg_len, s_axis_tlast, in_xfer};

    bmu_lite_reg #(.ADDR_W(ADDR_W)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .awaddr_i  (ctl_awaddr),
        .awvalid_i (ctl_awvalid),
        .awready_o (ctl_awready),
        .wdata_i   (ctl_wdata),
        .wvalid_i  (ctl_wvalid),
        .wready_o  (ctl_wready),
        .bresp_o   (ctl_bresp),
        .bvalid_o  (ctl_bvalid),
        .bready_i  (ctl_bready),
        .araddr_i  (ctl_araddr),
        .arvalid_i (ctl_arvalid),
        .arready_o (ctl_arready),
        .rdata_o   (ctl_rdata),
        .rresp_o   (ctl_rresp),
        .rvalid_o  (ctl_rvalid),
        .rready_i  (ctl_rready),
        .len_o     (cfg_len)
    );

    if (DIRECTION == DIR_INSERT) begin : g_insert
        logic [REG_W-1:0] len_sel;
        if (DYNAMIC != 0) begin : g_dyn
            assign len_sel = cfg_len;
        end else begin : g_static
            assign len_sel = REG_W'(STATIC_LEN);
        end
        bmu_beat_count #(.CW(REG_W)) u_cnt (
            .clk    (clk),
            .rst_n  (rst_n),
            .step_i (in_xfer),
            .len_i  (len_sel),
            .last_o (beat_last)
        );
    end else if (DIRECTION == DIR_STRIP) begin : g_strip
        assign beat_last = 1'b0;
    end else begin : g_bad_dir
        $fatal(1, "burst_mark_unit: DIRECTION must be 0 (insert) or 1 (strip)");
        assign beat_last = 1'b0;
    end

    bmu_out_stage #(.DW(DATA_W)) u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .s_valid_i (s_axis_tvalid),
        .s_ready_o (s_axis_tready),
        .s_data_i  (s_axis_tdata),
        .s_last_i  (beat_last),
        .m_valid_o (m_axis_tvalid),
        .m_ready_i (m_axis_tready),
        .m_data_o  (m_axis_tdata),
        .m_last_o  (m_axis_tlast),
        .xfer_o    (in_xfer)
    );
endmodule

// File: tb/test_burst_mark_unit.sv
`timescale 1ns/1ps
module test_burst_mark_unit;
    localparam int DW = 32;
    localparam int AW = 6;
    localparam int SLEN = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic          s_valid [3];
    logic [DW-1:0] s_data  [3];
    logic          s_tlast [3];
    logic          s_ready [3];
    logic          m_valid [3];
    logic [DW-1:0] m_data  [3];
    logic          m_tlast [3];
    logic          m_ready [3];

    logic [AW-1:0] awaddr = '0, araddr = '0;
    logic          awvalid = 1'b0, wvalid = 1'b0, arvalid = 1'b0;
    logic [31:0]   wdata = '0;
    logic          bready = 1'b1, rready = 1'b1;
    logic          awready [3];
    logic          wready  [3];
    logic [1:0]    bresp   [3];
    logic          bvalid  [3];
    logic          arready [3];
    logic [31:0]   rdata   [3];
    logic [1:0]    rresp   [3];
    logic          rvalid  [3];

    burst_mark_unit #(.DATA_W(DW), .DIRECTION(0), .DYNAMIC(1), .ADDR_W(AW)) i_burst_mark_unit (
        .clk(clk), .rst_n(rst_n),
        .s_axis_tvalid(s_valid[0]), .s_axis_tready(s_ready[0]), .s_axis_tdata(s_data[0]), .s_axis_tlast(s_tlast[0]),
        .m_axis_tvalid(m_valid[0]), .m_axis_tready(m_ready[0]), .m_axis_tdata(m_data[0]), .m_axis_tlast(m_tlast[0]),
        .ctl_awaddr(awaddr), .ctl_awvalid(awvalid), .ctl_awready(awready[0]), .ctl_wdata(wdata), .ctl_wvalid(wvalid),
        .ctl_wready(wready[0]), .ctl_bresp(bresp[0]), .ctl_bvalid(bvalid[0]), .ctl_bready(bready),
        .ctl_araddr(araddr), .ctl_arvalid(arvalid), .ctl_arready(arready[0]), .ctl_rdata(rdata[0]),
        .ctl_rresp(rresp[0]), .ctl_rvalid(rvalid[0]), .ctl_rready(rready));

    burst_mark_unit #(.DATA_W(DW), .DIRECTION(0), .DYNAMIC(0), .STATIC_LEN(SLEN), .ADDR_W(AW)) i_burst_mark_unit_static (
        .clk(clk), .rst_n(rst_n),
        .s_axis_tvalid(s_valid[1]), .s_axis_tready(s_ready[1]), .s_axis_tdata(s_data[1]), .s_axis_tlast(s_tlast[1]),
        .m_axis_tvalid(m_valid[1]), .m_axis_tready(m_ready[1]), .m_axis_tdata(m_data[1]), .m_axis_tlast(m_tlast[1]),
        .ctl_awaddr(awaddr), .ctl_awvalid(awvalid), .ctl_awready(awready[1]), .ctl_wdata(wdata), .ctl_wvalid(wvalid),
        .ctl_wready(wready[1]), .ctl_bresp(bresp[1]), .ctl_bvalid(bvalid[1]), .ctl_bready(bready),
        .ctl_araddr(araddr), .ctl_arvalid(arvalid), .ctl_arready(arready[1]), .ctl_rdata(rdata[1]),
        .ctl_rresp(rresp[1]), .ctl_rvalid(rvalid[1]), .ctl_rready(rready));

    burst_mark_unit #(.DATA_W(DW), .DIRECTION(1), .ADDR_W(AW)) i_burst_mark_unit_strip (
        .clk(clk), .rst_n(rst_n),
        .s_axis_tvalid(s_valid[2]), .s_axis_tready(s_ready[2]), .s_axis_tdata(s_data[2]), .s_axis_tlast(s_tlast[2]),
        .m_axis_tvalid(m_valid[2]), .m_axis_tready(m_ready[2]), .m_axis_tdata(m_data[2]), .m_axis_tlast(m_tlast[2]),
        .ctl_awaddr(awaddr), .ctl_awvalid(awvalid), .ctl_awready(awready[2]), .ctl_wdata(wdata), .ctl_wvalid(wvalid),
        .ctl_wready(wready[2]), .ctl_bresp(bresp[2]), .ctl_bvalid(bvalid[2]), .ctl_bready(bready),
        .ctl_araddr(araddr), .ctl_arvalid(arvalid), .ctl_arready(arready[2]), .ctl_rdata(rdata[2]),
        .ctl_rresp(rresp[2]), .ctl_rvalid(rvalid[2]), .ctl_rready(rready));

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // reference model state
    int unsigned mreg = 1;
    int unsigned mcnt [3];
    int unsigned mlen [3];
    logic [DW:0] eq0[$], eq1[$], eq2[$];
    bit          acc      [3];
    bit          stalled  [3];
    logic [DW:0] held     [3];
    bit          run = 1'b0, gen = 1'b0;
    int          rmode = 0;
    string       ph = "R9";

    task automatic model_clear();
        eq0.delete(); eq1.delete(); eq2.delete();
        for (int k = 0; k < 3; k++) begin
            mcnt[k] = 1; mlen[k] = 1; acc[k] = 1'b0; stalled[k] = 1'b0;
        end
        mreg = 1;
    endtask

    function automatic string req_of(input int k);
        if (k == 1) return "R3";
        if (k == 2) return "R7";
        return ph;
    endfunction

    task automatic push_exp(input int k, input logic [DW:0] v);
        if (k == 0) eq0.push_back(v); else if (k == 1) eq1.push_back(v); else eq2.push_back(v);
    endtask

    task automatic pop_exp(input int k, output bit ok, output logic [DW:0] v);
        ok = 1'b1; v = '0;
        if (k == 0) begin if (eq0.size() == 0) ok = 1'b0; else v = eq0.pop_front(); end
        else if (k == 1) begin if (eq1.size() == 0) ok = 1'b0; else v = eq1.pop_front(); end
        else begin if (eq2.size() == 0) ok = 1'b0; else v = eq2.pop_front(); end
    endtask

    // stream driver and per-cycle comparison
    always @(negedge clk) begin
        if (run) begin
            for (int k = 0; k < 3; k++) begin
                if (acc[k]) begin
                    s_data[k]  = s_data[k] + 32'h0001_0003;
                    s_valid[k] = gen && ($urandom_range(0, 9) < 7);
                    s_tlast[k] = $urandom_range(0, 1) == 1;
                end else if (!s_valid[k]) begin
                    s_valid[k] = gen && ($urandom_range(0, 9) < 7);
                    s_tlast[k] = $urandom_range(0, 1) == 1;
                end
                m_ready[k] = (rmode == 1) ? 1'b1 : (rmode == 2) ? 1'b0 : ($urandom_range(0, 9) < 6);
            end
            #1;
            for (int k = 0; k < 3; k++) begin
                bit          ok;
                logic [DW:0] v;
                if (stalled[k])
                    chk(m_valid[k] && {m_tlast[k], m_data[k]} == held[k], "R8",
                        64'({m_valid[k], m_tlast[k], m_data[k]}), 64'({1'b1, held[k]}));
                if (m_valid[k] && m_ready[k]) begin
                    pop_exp(k, ok, v);
                    if (!ok) chk(1'b0, "R8", 64'({m_tlast[k], m_data[k]}), 64'hDEAD);
                    else chk({m_tlast[k], m_data[k]} == v, req_of(k),
                             64'({m_tlast[k], m_data[k]}), 64'(v));
                end
                stalled[k] = m_valid[k] && !m_ready[k];
                held[k]    = {m_tlast[k], m_data[k]};
                acc[k]     = s_valid[k] && s_ready[k];
                if (acc[k]) begin
                    bit last;
                    if (k == 2) last = 1'b0;
                    else begin
                        int unsigned live;
                        live = (k == 1) ? SLEN : ((mreg == 0) ? 1 : mreg);
                        if (mcnt[k] == 1) mlen[k] = live;
                        last = (mcnt[k] >= mlen[k]);
                        mcnt[k] = last ? 1 : mcnt[k] + 1;
                    end
                    push_exp(k, {last, s_data[k]});
                end
            end
        end
    end

    task automatic lite_write(input logic [AW-1:0] a, input logic [31:0] d);
        @(negedge clk);
        awaddr = a; wdata = d; awvalid = 1'b1; wvalid = 1'b1;
        #1;
        while (!awready[0]) begin @(negedge clk); #1; end
        @(posedge clk);
        if (a[AW-1:2] == 4'h4) mreg = d;
        @(negedge clk);
        awvalid = 1'b0; wvalid = 1'b0;
        #1;
        chk(bvalid[0] && bresp[0] == 2'b00, "R10", 64'({bvalid[0], bresp[0]}), 64'h4);
    endtask

    task automatic lite_read(input logic [AW-1:0] a, input logic [31:0] exp, input string req);
        @(negedge clk);
        araddr = a; arvalid = 1'b1;
        #1;
        while (!arready[0]) begin @(negedge clk); #1; end
        @(posedge clk);
        @(negedge clk);
        arvalid = 1'b0;
        #1;
        chk(rvalid[0] && rresp[0] == 2'b00, "R10", 64'({rvalid[0], rresp[0]}), 64'h4);
        chk(rdata[0] == exp, req, 64'(rdata[0]), 64'(exp));
    endtask

    task automatic drain_and_check();
        gen = 1'b0; rmode = 1;
        repeat (25) @(posedge clk);
        chk(eq0.size() == 0, "R8", 64'(eq0.size()), 64'h0);
        chk(eq1.size() == 0, "R8", 64'(eq1.size()), 64'h0);
        chk(eq2.size() == 0, "R8", 64'(eq2.size()), 64'h0);
    endtask

    task automatic hard_reset();
        @(posedge clk); #1;
        run = 1'b0;
        for (int k = 0; k < 3; k++) begin s_valid[k] = 1'b0; m_ready[k] = 1'b0; end
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        model_clear();
        @(negedge clk);
        for (int k = 0; k < 3; k++)
            chk(!m_valid[k], "R9", 64'(m_valid[k]), 64'h0);
        rst_n = 1'b1;
    endtask

    initial begin
        for (int k = 0; k < 3; k++) begin
            s_valid[k] = 1'b0; s_data[k] = 32'(k * 1000); s_tlast[k] = 1'b0; m_ready[k] = 1'b0;
        end
        model_clear();
        hard_reset();
        lite_read(6'h10, 32'd1, "R9");
        // reset value 1: every beat marked
        ph = "R9"; gen = 1'b1; run = 1'b1; rmode = 0;
        repeat (30) @(posedge clk);
        ph = "R2";
        lite_write(6'h10, 32'd5);
        lite_read(6'h13, 32'd5, "R2");
        repeat (150) @(posedge clk);
        // writes landing inside groups
        ph = "R5";
        lite_write(6'h10, 32'd3);
        repeat (4) @(posedge clk);
        lite_write(6'h10, 32'd7);
        repeat (2) @(posedge clk);
        lite_write(6'h10, 32'd2);
        repeat (120) @(posedge clk);
        ph = "R6";
        lite_write(6'h10, 32'd0);
        lite_read(6'h10, 32'd0, "R6");
        repeat (40) @(posedge clk);
        // unmapped offset
        lite_write(6'h04, 32'd9);
        lite_read(6'h04, 32'd0, "R10");
        lite_read(6'h10, 32'd0, "R10");
        // full stall, then release
        ph = "R8";
        lite_write(6'h10, 32'd3);
        rmode = 2; repeat (12) @(posedge clk);
        rmode = 1; repeat (20) @(posedge clk);
        rmode = 0;
        ph = "R4";
        lite_write(6'h10, 32'd6);
        repeat (100) @(posedge clk);
        ph = "R1";
        rmode = 1; repeat (60) @(posedge clk);
        rmode = 0;
        drain_and_check();
        // reset in the middle of a group
        gen = 1'b1; rmode = 0;
        repeat (7) @(posedge clk);
        hard_reset();
        lite_read(6'h10, 32'd1, "R9");
        ph = "R9";
        run = 1'b1; gen = 1'b1;
        lite_write(6'h10, 32'd5);
        ph = "R1";
        repeat (80) @(posedge clk);
        drain_and_check();
        run = 1'b0;
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule